// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block chooses the value that feeds each of the two ALU inputs in a five-stage pipeline. For every operand it compares the source register number of the instruction in execute with the destination numbers of the two older instructions. One sits in the execute/memory boundary register and one in the memory/writeback boundary register. When the needed value has been computed but not yet written back, the block routes it straight to the ALU. Otherwise the register file read value passes through. The forwarded results still travel on to writeback; this unit only adds a path toward the ALU.

The logic is purely combinational and has a parameterised data width and register number width. A producer takes part only if it is live (not squashed into a no-op), writes a register, and targets a register other than 0. When both older instructions write the source register, the younger one wins. That is the one in the execute/memory register. An execute/memory load cannot supply its data yet, so its match is ignored and the choice falls to the next candidate. Holding the pipeline for that case is left to separate stall logic.

Top module: `alu_bypass_unit`

## Requirements
- R1: With no qualifying producer for an operand, its select code is 2'b00 and the operand equals that operand's register file value.
- R2: When only the execute/memory producer qualifies for an operand (live, writing, destination nonzero, not a load, destination equal to the source), the select code is 2'b10 and the operand equals the execute/memory data.
- R3: When only the memory/writeback producer qualifies (live, writing, destination nonzero, destination equal to the source), the select code is 2'b01 and the operand equals the memory/writeback data.
- R4: When both producers qualify for the same operand, the execute/memory producer is chosen (select 2'b10).
- R5: A destination of register 0 never qualifies, so a source of 0 always yields select 2'b00.
- R6: A producer whose live flag is low (squashed), or whose write flag is low, never qualifies.
- R7: An execute/memory producer flagged as a load never qualifies; the operand then takes the memory/writeback data if that producer qualifies (select 2'b01), else the register file value (select 2'b00).
- R8: The two operands are resolved independently: each may carry a different select code in the same cycle.
- R9: A select code never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_a | input | REG_W | Source register number for operand A of the execute-stage instruction |
| ex_rs_b | input | REG_W | Source register number for operand B |
| rf_val_a | input | DATA_W | Register file read value for operand A |
| rf_val_b | input | DATA_W | Register file read value for operand B |
| xm_rd | input | REG_W | Destination register of the execute/memory instruction |
| xm_we | input | 1 | Execute/memory instruction writes a register |
| xm_live | input | 1 | Execute/memory instruction is valid (not squashed) |
| xm_load | input | 1 | Execute/memory instruction is a load, data not yet available |
| xm_data | input | DATA_W | Result held in the execute/memory register |
| mw_rd | input | REG_W | Destination register of the memory/writeback instruction |
| mw_we | input | 1 | Memory/writeback instruction writes a register |
| mw_live | input | 1 | Memory/writeback instruction is valid |
| mw_data | input | DATA_W | Result held in the memory/writeback register |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |
| sel_a | output | 2 | Select code for operand A (00 register file, 01 memory/writeback, 10 execute/memory) |
| sel_b | output | 2 | Select code for operand B |

## Verification
The hardest case is a load in the execute/memory register that targets the same register as a live writer in memory/writeback. Squash and write-enable flags must also mask one or the other producer in that same case. Most random register choices never make such three-way collisions. The table therefore places them on purpose, with the two operands set to different outcomes in one vector. The random phase then draws register numbers from a narrow range that includes 0, so matches, zero destinations and load masking happen often, and the bench checks each result against its own priority model.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

   typedef enum logic [1:0] {
      BYP_RF = 2'b00,
      BYP_MW = 2'b01,
      BYP_XM = 2'b10
   } byp_sel_e;

   localparam int NUM_OPND = 2;

endpackage

// File: rtl/byp_hit.sv
module byp_hit #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   input  logic             live,
   input  logic             blocked,
   output logic             hit
);

   localparam logic [REG_W-1:0] ZERO_REG = '0;

   logic producer_ok;

   assign producer_ok = live & wen & ~blocked & (dst != ZERO_REG);
   assign hit         = producer_ok & (dst == src);

endmodule

// File: rtl/byp_operand.sv
module byp_operand
   import bypass_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic [REG_W-1:0]  src,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [REG_W-1:0]  xm_rd,
   input  logic              xm_we,
   input  logic              xm_live,
   input  logic              xm_load,
   input  logic [DATA_W-1:0] xm_data,
   input  logic [REG_W-1:0]  mw_rd,
   input  logic              mw_we,
   input  logic              mw_live,
   input  logic [DATA_W-1:0] mw_data,
   output logic [1:0]        sel,
   output logic [DATA_W-1:0] opnd
);

   logic     xm_hit;
   logic     mw_hit;
   byp_sel_e pick;

   byp_hit #(.REG_W(REG_W)) u_xm_hit (
      .src     (src),
      .dst     (xm_rd),
      .wen     (xm_we),
      .live    (xm_live),
      .blocked (xm_load),
      .hit     (xm_hit)
   );

   byp_hit #(.REG_W(REG_W)) u_mw_hit (
      .src     (src),
      .dst     (mw_rd),
      .wen     (mw_we),
      .live    (mw_live),
      .blocked (1'b0),
      .hit     (mw_hit)
   );

   always_comb begin
      if (xm_hit) begin
         pick = BYP_XM;
      end else if (mw_hit) begin
         pick = BYP_MW;
      end else begin
         pick = BYP_RF;
      end
   end

   always_comb begin
      unique case (pick)
         BYP_XM:  opnd = xm_data;
         BYP_MW:  opnd = mw_data;
         default: opnd = rf_val;
      endcase
   end

   assign sel = pick;

endmodule

// File: rtl/alu_bypass_unit.sv
module alu_bypass_unit
   import bypass_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic [REG_W-1:0]  ex_rs_a,
   input  logic [REG_W-1:0]  ex_rs_b,
   input  logic [DATA_W-1:0] rf_val_a,
   input  logic [DATA_W-1:0] rf_val_b,
   input  logic [REG_W-1:0]  xm_rd,
   input  logic              xm_we,
   input  logic              xm_live,
   input  logic              xm_load,
   input  logic [DATA_W-1:0] xm_data,
   input  logic [REG_W-1:0]  mw_rd,
   input  logic              mw_we,
   input  logic              mw_live,
   input  logic [DATA_W-1:0] mw_data,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("alu_bypass_unit: DATA_W must be at least 1");
      end
      if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
         $error("alu_bypass_unit: REG_W must lie in 1..8");
      end
   endgenerate

   logic [REG_W-1:0]  src_v  [NUM_OPND];
   logic [DATA_W-1:0] rf_v   [NUM_OPND];
   logic [DATA_W-1:0] opnd_v [NUM_OPND];
   logic [1:0]        sel_v  [NUM_OPND];

   assign src_v[0] = ex_rs_a;
   assign src_v[1] = ex_rs_b;
   assign rf_v[0]  = rf_val_a;
   assign rf_v[1]  = rf_val_b;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         byp_operand #(
            .DATA_W (DATA_W),
            .REG_W  (REG_W)
         ) u_opnd (
            .src     (src_v[g]),
            .rf_val  (rf_v[g]),
            .xm_rd   (xm_rd),
            .xm_we   (xm_we),
            .xm_live (xm_live),
            .xm_load (xm_load),
            .xm_data (xm_data),
            .mw_rd   (mw_rd),
            .mw_we   (mw_we),
            .mw_live (mw_live),
            .mw_data (mw_data),
            .sel     (sel_v[g]),
            .opnd    (opnd_v[g])
         );
      end
   endgenerate

   assign opnd_a = opnd_v[0];
   assign opnd_b = opnd_v[1];
   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];

endmodule

// File: rtl/bypass_chk.sv
module bypass_chk #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input logic [REG_W-1:0]  ex_rs_a,
   input logic [REG_W-1:0]  ex_rs_b,
   input logic [DATA_W-1:0] rf_val_a,
   input logic [DATA_W-1:0] rf_val_b,
   input logic [REG_W-1:0]  xm_rd,
   input logic              xm_we,
   input logic              xm_live,
   input logic              xm_load,
   input logic [DATA_W-1:0] xm_data,
   input logic [REG_W-1:0]  mw_rd,
   input logic              mw_we,
   input logic              mw_live,
   input logic [DATA_W-1:0] mw_data,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b
);

   logic [REG_W-1:0]  c_src  [2];
   logic [DATA_W-1:0] c_rf   [2];
   logic [DATA_W-1:0] c_opnd [2];
   logic [1:0]        c_sel  [2];

   assign c_src[0]  = ex_rs_a;
   assign c_src[1]  = ex_rs_b;
   assign c_rf[0]   = rf_val_a;
   assign c_rf[1]   = rf_val_b;
   assign c_opnd[0] = opnd_a;
   assign c_opnd[1] = opnd_b;
   assign c_sel[0]  = sel_a;
   assign c_sel[1]  = sel_b;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_chk
         always_comb begin
            AST_SEL_CODE_LEGAL: assert (c_sel[g] != 2'b11); // R9
            AST_XM_PICK_QUALIFIED: assert (c_sel[g] != 2'b10 ||
               (xm_live && xm_we && !xm_load && (xm_rd != '0) && (xm_rd == c_src[g]))); // R2
            AST_MW_PICK_QUALIFIED: assert (c_sel[g] != 2'b01 ||
               (mw_live && mw_we && (mw_rd != '0) && (mw_rd == c_src[g]))); // R3
            AST_YOUNGEST_WINS: assert (!(xm_live && xm_we && !xm_load && (xm_rd != '0) &&
               (xm_rd == c_src[g]) && mw_live && mw_we && (mw_rd == c_src[g])) ||
               c_sel[g] == 2'b10); // R4
            AST_ZERO_SRC_UNBYPASSED: assert (c_src[g] != '0 || c_sel[g] == 2'b00); // R5
            AST_LOAD_NOT_FROM_XM: assert (!xm_load || c_sel[g] != 2'b10); // R7
            AST_OPND_FOLLOWS_SEL: assert (c_opnd[g] ==
               ((c_sel[g] == 2'b10) ? xm_data : ((c_sel[g] == 2'b01) ? mw_data : c_rf[g]))); // R1
         end
      end
   endgenerate

endmodule

bind alu_bypass_unit bypass_chk #(
   .DATA_W (DATA_W),
   .REG_W  (REG_W)
) u_bypass_chk (
   .ex_rs_a  (ex_rs_a),
   .ex_rs_b  (ex_rs_b),
   .rf_val_a (rf_val_a),
   .rf_val_b (rf_val_b),
   .xm_rd    (xm_rd),
   .xm_we    (xm_we),
   .xm_live  (xm_live),
   .xm_load  (xm_load),
   .xm_data  (xm_data),
   .mw_rd    (mw_rd),
   .mw_we    (mw_we),
   .mw_live  (mw_live),
   .mw_data  (mw_data),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .sel_a    (sel_a),
   .sel_b    (sel_b)
);

// File: tb/tb_alu_bypass_unit.sv
module tb_alu_bypass_unit;

   localparam int DW = 32;
   localparam int RW = 5;
   localparam int NV = 14;
   localparam int WATCHDOG_CYC = 20000;

   typedef struct packed {
      logic [4:0] sa;
      logic [4:0] sb;
      logic [4:0] xrd;
      logic       xwe;
      logic       xlive;
      logic       xload;
      logic [4:0] mrd;
      logic       mwe;
      logic       mlive;
      logic [1:0] ea;
      logic [1:0] eb;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{5'd3,  5'd4,  5'd5,  1'b1, 1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 2'b00, 2'b00}, // R1
      '{5'd5,  5'd4,  5'd5,  1'b1, 1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 2'b10, 2'b00}, // R2
      '{5'd3,  5'd6,  5'd5,  1'b1, 1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 2'b00, 2'b01}, // R3
      '{5'd7,  5'd7,  5'd7,  1'b1, 1'b1, 1'b0, 5'd7,  1'b1, 1'b1, 2'b10, 2'b10}, // R4
      '{5'd7,  5'd9,  5'd7,  1'b1, 1'b1, 1'b0, 5'd9,  1'b1, 1'b1, 2'b10, 2'b01}, // R8
      '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 1'b1, 2'b00, 2'b00}, // R5
      '{5'd7,  5'd7,  5'd7,  1'b1, 1'b0, 1'b0, 5'd7,  1'b1, 1'b1, 2'b01, 2'b01}, // R6 xm squashed
      '{5'd7,  5'd3,  5'd7,  1'b0, 1'b1, 1'b0, 5'd3,  1'b1, 1'b1, 2'b00, 2'b01}, // R6 xm no write
      '{5'd7,  5'd7,  5'd2,  1'b1, 1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 2'b00, 2'b00}, // R6 mw squashed
      '{5'd7,  5'd7,  5'd2,  1'b1, 1'b1, 1'b0, 5'd7,  1'b0, 1'b1, 2'b00, 2'b00}, // R6 mw no write
      '{5'd7,  5'd7,  5'd7,  1'b1, 1'b1, 1'b1, 5'd7,  1'b1, 1'b1, 2'b01, 2'b01}, // R7 falls to mw
      '{5'd7,  5'd4,  5'd7,  1'b1, 1'b1, 1'b1, 5'd4,  1'b1, 1'b1, 2'b00, 2'b01}, // R7 falls to rf
      '{5'd0,  5'd8,  5'd8,  1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 1'b1, 2'b00, 2'b10}, // R5 mw zero
      '{5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1, 2'b10, 2'b10}  // R4 top register
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic [RW-1:0] ex_rs_a, ex_rs_b, xm_rd, mw_rd;
   logic [DW-1:0] rf_val_a, rf_val_b, xm_data, mw_data, opnd_a, opnd_b;
   logic          xm_we, xm_live, xm_load, mw_we, mw_live;
   logic [1:0]    sel_a, sel_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   alu_bypass_unit #(.DATA_W(DW), .REG_W(RW)) dut (
      .ex_rs_a (ex_rs_a), .ex_rs_b (ex_rs_b),
      .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
      .xm_rd   (xm_rd), .xm_we(xm_we), .xm_live(xm_live), .xm_load(xm_load), .xm_data(xm_data),
      .mw_rd   (mw_rd), .mw_we(mw_we), .mw_live(mw_live), .mw_data(mw_data),
      .opnd_a  (opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] ref_sel(input logic [RW-1:0] s);
      logic xq, mq;
      xq = xm_live && xm_we && !xm_load && (xm_rd != 0) && (xm_rd == s);
      mq = mw_live && mw_we && (mw_rd != 0) && (mw_rd == s);
      if (xq)      return 2'b10;
      else if (mq) return 2'b01;
      else         return 2'b00;
   endfunction

   function automatic logic [DW-1:0] ref_val(input logic [1:0] s, input logic [DW-1:0] rf);
      return (s == 2'b10) ? xm_data : ((s == 2'b01) ? mw_data : rf);
   endfunction

   task automatic check_both(input string tag, input logic [1:0] ea, input logic [1:0] eb);
      chk({tag, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
      chk({tag, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
      chk({tag, " opnd_a"}, opnd_a, ref_val(ea, rf_val_a));
      chk({tag, " opnd_b"}, opnd_b, ref_val(eb, rf_val_b));
   endtask

   initial begin
      ex_rs_a = '0; ex_rs_b = '0; xm_rd = '0; mw_rd = '0;
      xm_we = 1'b0; xm_live = 1'b0; xm_load = 1'b0; mw_we = 1'b0; mw_live = 1'b0;
      rf_val_a = 32'h1111_0001; rf_val_b = 32'h2222_0002;
      xm_data = 32'h3333_0003; mw_data = 32'h4444_0004;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_both("R1 reset idle", 2'b00, 2'b00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ex_rs_a = VECS[i].sa;  ex_rs_b = VECS[i].sb;
         xm_rd = VECS[i].xrd; xm_we = VECS[i].xwe; xm_live = VECS[i].xlive; xm_load = VECS[i].xload;
         mw_rd = VECS[i].mrd; mw_we = VECS[i].mwe; mw_live = VECS[i].mlive;
         rf_val_a = 32'hA000_0000 + i; rf_val_b = 32'hB000_0000 + i;
         xm_data  = 32'hC000_0000 + i; mw_data  = 32'hD000_0000 + i;
         #1;
         check_both($sformatf("R1-table vector %0d", i), VECS[i].ea, VECS[i].eb);
      end

      // R7: squashed load combined with mw hit on the other operand only
      @(negedge clk);
      ex_rs_a = 5'd2; ex_rs_b = 5'd3; xm_rd = 5'd2; xm_we = 1'b1; xm_live = 1'b0; xm_load = 1'b1;
      mw_rd = 5'd3; mw_we = 1'b1; mw_live = 1'b1;
      #1;
      check_both("R7 squashed load", 2'b00, 2'b01);

      // Random phase against priority model: R4 R5 R6 R7 R9
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         ex_rs_a = RW'($urandom_range(0, 3)); ex_rs_b = RW'($urandom_range(0, 3));
         xm_rd = RW'($urandom_range(0, 3)); mw_rd = RW'($urandom_range(0, 3));
         xm_we = 1'($urandom); xm_live = 1'($urandom); xm_load = 1'($urandom);
         mw_we = 1'($urandom); mw_live = 1'($urandom);
         rf_val_a = $urandom; rf_val_b = $urandom; xm_data = $urandom; mw_data = $urandom;
         #1;
         check_both("R4 random", ref_sel(ex_rs_a), ref_sel(ex_rs_b));
         chk("R9 code a", {31'd0, sel_a == 2'b11}, 32'd0);
         chk("R9 code b", {31'd0, sel_b == 2'b11}, 32'd0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule